// File: doc/BRIEF.md
# Program Counter and Call/Interrupt Sequencer

This block holds the program counter of a small 4-bit processor core and works out the next fetch address each time an instruction completes. The core's decoder hands it the first and second opcode bytes, a one-byte/two-byte length flag for ordinary instructions and the current status flag. From these the block selects among plain advance, a page-relative short branch, a long branch, a call into a sparse table of short-call slots, a long call into the low 2K, return, and return-from-interrupt. The program counter width is a parameter: 12 bits for a 4K space or 13 bits for an 8K space.

Prioritised interrupt requests are taken at instruction boundaries while interrupts are enabled. Taking one replaces the pending instruction with a jump to a fixed even vector near address zero. A return stack of parameterised depth keeps return addresses. For an interrupt it also keeps the four core flags, and a return-from-interrupt hands those flags back to the core. The stack pointer can be loaded to pick the starting level. Overflow and underflow are reported by sticky flags, and the pointer saturates instead of wrapping.

Top module: `pc_sequencer`

## Requirements
- R1: Asynchronous active-low reset sets `pc` to 0, `sp` to 0, and clears `int_en`, `stack_ovf`, `stack_unf`, `flags_load`, `flags_out` and `irq_ack`.
- R2: All results are registered and appear one clock after an edge with `step` high. Without `step`, `pc` holds. An opcode not covered by R3 to R8 advances `pc` by 2 when `two_byte` is 1, otherwise by 1, modulo 2^PC_W.
- R3: First byte `00xxxxxx` is a short branch. When `sf`=1 the new `pc` keeps bits PC_W-1..6 of `pc`+1 and takes the low 6 bits from the opcode. When `sf`=0 it is `pc`+1.
- R4: First byte `1100hhhh` with second byte `llllllll` is a long branch. When `sf`=1 the low 12 bits of `pc` become `hhhhllllllll` and any bits above 11 are kept. When `sf`=0, `pc` advances by 2.
- R5: First byte `1110nnnn` is a short call. It pushes `pc`+1 and jumps to 8n+6, or to 086h when n=0.
- R6: First byte `01000hhh` with second byte `llllllll` is a long call. It pushes `pc`+2 and jumps to the zero-extended 11-bit address `hhhllllllll`.
- R7: Byte 4Fh is a return. It pops the saved address into `pc`, decrements `sp` and leaves `int_en` unchanged.
- R8: Byte 4Dh is a return-from-interrupt. It pops the address into `pc`, sets `int_en`, drives the saved flags on `flags_out` and pulses `flags_load` for one cycle.
- R9: When `step` is high, `int_en` is 1 and any `irq_req` bit is set, the interrupt is taken in place of the instruction. The current `pc` and `flags_in` are pushed, `pc` loads vector 2*(i+1), `int_en` clears and `irq_ack` pulses bit i for one cycle. While `int_en` is 0, requests are ignored.
- R10: Among simultaneous requests, the lowest index wins. Index 0 maps to vector 002h and index 5 maps to vector 00Ch.
- R11: `sp_wr` loads `sp` from `sp_wdata`, saturated to STACK_DEPTH. Later pushes and pops continue from that level.
- R12: A push while `sp` equals STACK_DEPTH sets the sticky `stack_ovf`, leaves `sp` and the stack unchanged, and still jumps to the call or vector target.
- R13: A pop while `sp` is 0 sets the sticky `stack_unf`, keeps `sp` at 0 and advances `pc` by 1, with no `flags_load`. A return-from-interrupt in this case still sets `int_en`.
- R14: Without `step`, `int_en_set` sets `int_en` and `int_en_clr` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step | input | 1 | The instruction on the opcode inputs completes this cycle |
| op_b0 | input | 8 | First opcode byte |
| op_b1 | input | 8 | Second opcode byte (address low part) |
| two_byte | input | 1 | Length of an ordinary instruction: 1 means two bytes |
| sf | input | 1 | Status flag that conditions branches |
| flags_in | input | 4 | Core flags {CF,ZF,SF,GF}, saved on interrupt entry |
| irq_req | input | N_IRQ | Interrupt request lines, index 0 highest priority |
| int_en_set | input | 1 | Enable interrupts |
| int_en_clr | input | 1 | Disable interrupts |
| sp_wr | input | 1 | Load stack pointer |
| sp_wdata | input | clog2(STACK_DEPTH+1) | New stack pointer value |
| pc | output | PC_W | Program counter |
| sp | output | clog2(STACK_DEPTH+1) | Number of occupied stack levels |
| int_en | output | 1 | Interrupt enable |
| irq_ack | output | N_IRQ | One-cycle grant of the interrupt taken |
| flags_load | output | 1 | One-cycle pulse: restore flags from `flags_out` |
| flags_out | output | 4 | Flags popped by the last return-from-interrupt |
| stack_ovf | output | 1 | Sticky stack overflow |
| stack_unf | output | 1 | Sticky stack underflow |

## Verification
Every result of a step is due on the first clock after the edge that samples `step`. This holds for `pc`, `sp`, `int_en` and the sticky error flags, which then hold, and for the one-cycle `flags_load` and `irq_ack` pulses, which drop on the following edge. The reference model advances on each rising edge and is compared a quarter period later, so each pulse is seen in exactly its one cycle. Directed checks sample at the falling edge right after the stepping edge, with hand-computed targets: page-crossing short branches, long branches above 4K, the n=0 short call, vector priority, and both stack limits.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   localparam int FLAG_W = 4;

   typedef enum logic [2:0] {
      OPK_SEQ,
      OPK_SBR,
      OPK_LBR,
      OPK_SCALL,
      OPK_LCALL,
      OPK_RET,
      OPK_RTI
   } op_kind_e;

endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
   import pcs_pkg::*;
(
   input  logic [7:0] opc,
   output op_kind_e   kind
);

   always_comb begin
      kind = OPK_SEQ;
      if (opc[7:6] == 2'b00)        kind = OPK_SBR;
      else if (opc[7:4] == 4'b1100) kind = OPK_LBR;
      else if (opc[7:4] == 4'b1110) kind = OPK_SCALL;
      else if (opc[7:3] == 5'b01000) kind = OPK_LCALL;
      else if (opc == 8'h4F)        kind = OPK_RET;
      else if (opc == 8'h4D)        kind = OPK_RTI;
   end

endmodule

// File: rtl/pcs_irq_pick.sv
module pcs_irq_pick #(
   parameter  int N  = 6,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx
);

   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_pri
      assign grant[i]  = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end

   assign any = seen[N];

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
   parameter  int DEPTH = 13,
   parameter  int DW    = 17,
   localparam int SPW   = $clog2(DEPTH + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           push,
   input  logic           pop,
   input  logic [DW-1:0]  wdata,
   input  logic           sp_load,
   input  logic [SPW-1:0] sp_val,
   output logic [DW-1:0]  top_q,
   output logic [SPW-1:0] sp,
   output logic           empty,
   output logic           ovf,
   output logic           unf
);

   logic [DW-1:0]  mem [DEPTH];
   logic [SPW-1:0] sp_q;
   logic [SPW-1:0] rd_idx;
   logic           full;
   logic           do_push;
   logic           ovf_q;
   logic           unf_q;

   assign empty   = (sp_q == '0);
   assign full    = (sp_q == SPW'(DEPTH));
   assign do_push = push && !full && !sp_load;
   assign rd_idx  = sp_q - SPW'(1);
   assign top_q   = empty ? '0 : mem[rd_idx];
   assign sp      = sp_q;
   assign ovf     = ovf_q;
   assign unf     = unf_q;

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            mem[e] <= '0;
         else if (do_push && sp_q == SPW'(e))   mem[e] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q  <= '0;
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else if (sp_load) begin
         sp_q <= (sp_val > SPW'(DEPTH)) ? SPW'(DEPTH) : sp_val;
      end else if (push) begin
         if (full) ovf_q <= 1'b1;
         else      sp_q  <= sp_q + SPW'(1);
      end else if (pop) begin
         if (empty) unf_q <= 1'b1;
         else       sp_q  <= sp_q - SPW'(1);
      end
   end

   // R12
   sp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sp_q <= SPW'(DEPTH));

   // R12
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);

   // R13
   unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unf_q |=> unf_q);

   // R12
   full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !sp_load) |=> (sp_q == SPW'(DEPTH) && ovf_q));

   // R7
   pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !empty && !sp_load) |=> (sp_q == $past(sp_q) - SPW'(1)));

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
   import pcs_pkg::*;
#(
   parameter  int PC_W        = 13,
   parameter  int STACK_DEPTH = 13,
   parameter  int N_IRQ       = 6,
   localparam int SP_W        = $clog2(STACK_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic [7:0]        op_b0,
   input  logic [7:0]        op_b1,
   input  logic              two_byte,
   input  logic              sf,
   input  logic [FLAG_W-1:0] flags_in,
   input  logic [N_IRQ-1:0]  irq_req,
   input  logic              int_en_set,
   input  logic              int_en_clr,
   input  logic              sp_wr,
   input  logic [SP_W-1:0]   sp_wdata,
   output logic [PC_W-1:0]   pc,
   output logic [SP_W-1:0]   sp,
   output logic              int_en,
   output logic [N_IRQ-1:0]  irq_ack,
   output logic              flags_load,
   output logic [FLAG_W-1:0] flags_out,
   output logic              stack_ovf,
   output logic              stack_unf
);

   localparam int DW = PC_W + FLAG_W;
   localparam int IW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

   if (PC_W < 12 || PC_W > 16) begin : g_bad_pcw
      $error("pc_sequencer: PC_W must lie in 12..16");
   end
   if (STACK_DEPTH < 1 || STACK_DEPTH > 31) begin : g_bad_depth
      $error("pc_sequencer: STACK_DEPTH must lie in 1..31");
   end
   if (N_IRQ < 1 || N_IRQ > 6) begin : g_bad_nirq
      $error("pc_sequencer: vectors must stay below the short-call table");
   end

   op_kind_e          kind;
   logic              irq_any;
   logic [N_IRQ-1:0]  irq_grant;
   logic [IW-1:0]     irq_idx;
   logic              take;
   logic [PC_W-1:0]   pc_q, pc_d, pc_p1, pc_p2;
   logic [PC_W-1:0]   sbr_tgt, lbr_tgt, scall_tgt, lcall_tgt, vec;
   logic              st_push, st_pop, st_empty;
   logic [DW-1:0]     st_wdata, st_top;
   logic              ie_q, fl_load_q, rti_pop;
   logic [FLAG_W-1:0] fl_out_q;
   logic [N_IRQ-1:0]  ack_q;

   pcs_decode u_dec (
      .opc  (op_b0),
      .kind (kind)
   );

   pcs_irq_pick #(.N(N_IRQ)) u_pick (
      .req   (irq_req),
      .any   (irq_any),
      .grant (irq_grant),
      .idx   (irq_idx)
   );

   pcs_stack #(.DEPTH(STACK_DEPTH), .DW(DW)) u_stk (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (st_push),
      .pop     (st_pop),
      .wdata   (st_wdata),
      .sp_load (sp_wr),
      .sp_val  (sp_wdata),
      .top_q   (st_top),
      .sp      (sp),
      .empty   (st_empty),
      .ovf     (stack_ovf),
      .unf     (stack_unf)
   );

   assign take    = step && ie_q && irq_any;
   assign pc_p1   = pc_q + PC_W'(1);
   assign pc_p2   = pc_q + PC_W'(2);
   assign sbr_tgt = {pc_p1[PC_W-1:6], op_b0[5:0]};
   assign vec     = PC_W'((int'(irq_idx) + 1) * 2);
   assign scall_tgt = (op_b0[3:0] == 4'd0) ? PC_W'(8'h86) : PC_W'({op_b0[3:0], 3'b110});
   assign lcall_tgt = PC_W'({op_b0[2:0], op_b1});

   if (PC_W > 12) begin : g_lbr_keep
      assign lbr_tgt = {pc_q[PC_W-1:12], op_b0[3:0], op_b1};
   end else begin : g_lbr_flat
      assign lbr_tgt = {op_b0[3:0], op_b1};
   end

   always_comb begin
      pc_d     = pc_q;
      st_push  = 1'b0;
      st_pop   = 1'b0;
      st_wdata = {pc_q, flags_in};
      rti_pop  = 1'b0;
      if (step) begin
         if (take) begin
            pc_d    = vec;
            st_push = 1'b1;
         end else begin
            case (kind)
               OPK_SBR:   pc_d = sf ? sbr_tgt : pc_p1;
               OPK_LBR:   pc_d = sf ? lbr_tgt : pc_p2;
               OPK_SCALL: begin
                  st_push  = 1'b1;
                  st_wdata = {pc_p1, flags_in};
                  pc_d     = scall_tgt;
               end
               OPK_LCALL: begin
                  st_push  = 1'b1;
                  st_wdata = {pc_p2, flags_in};
                  pc_d     = lcall_tgt;
               end
               OPK_RET, OPK_RTI: begin
                  st_pop  = 1'b1;
                  pc_d    = st_empty ? pc_p1 : st_top[DW-1:FLAG_W];
                  rti_pop = (kind == OPK_RTI) && !st_empty;
               end
               default:   pc_d = two_byte ? pc_p2 : pc_p1;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q      <= '0;
         ie_q      <= 1'b0;
         fl_load_q <= 1'b0;
         fl_out_q  <= '0;
         ack_q     <= '0;
      end else begin
         pc_q      <= pc_d;
         fl_load_q <= rti_pop;
         ack_q     <= take ? irq_grant : '0;
         if (rti_pop) fl_out_q <= st_top[FLAG_W-1:0];
         if (take)                                ie_q <= 1'b0;
         else if (step && kind == OPK_RTI)        ie_q <= 1'b1;
         else if (!step && int_en_set)            ie_q <= 1'b1;
         else if (!step && int_en_clr)            ie_q <= 1'b0;
      end
   end

   assign pc         = pc_q;
   assign int_en     = ie_q;
   assign irq_ack    = ack_q;
   assign flags_load = fl_load_q;
   assign flags_out  = fl_out_q;

   // R9
   take_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !int_en);

   // R8
   rti_sets_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !take && kind == OPK_RTI) |=> int_en);

   // R5
   scall_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !take && kind == OPK_SCALL) |=> (pc[2:0] == 3'b110));

   // R10
   ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_ack));

   // R9
   ack_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_ack) |-> (pc[0] == 1'b0 && pc <= PC_W'(2 * N_IRQ)));

   // R2
   hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(pc));

endmodule

// File: tb/sim_pc_sequencer.sv
module sim_pc_sequencer;

   localparam int CLK_PERIOD = 10;
   localparam int PC_W  = 13;
   localparam int DEPTH = 13;
   localparam int NIRQ  = 6;
   localparam int SPW   = $clog2(DEPTH + 1);
   localparam int MASK  = (1 << PC_W) - 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            step = 1'b0;
   logic [7:0]      op_b0 = '0, op_b1 = '0;
   logic            two_byte = 1'b0, sf = 1'b0;
   logic [3:0]      flags_in = '0;
   logic [NIRQ-1:0] irq_req = '0;
   logic            int_en_set = 1'b0, int_en_clr = 1'b0;
   logic            sp_wr = 1'b0;
   logic [SPW-1:0]  sp_wdata = '0;
   logic [PC_W-1:0] pc;
   logic [SPW-1:0]  sp;
   logic            int_en, flags_load, stack_ovf, stack_unf;
   logic [NIRQ-1:0] irq_ack;
   logic [3:0]      flags_out;

   pc_sequencer #(.PC_W(PC_W), .STACK_DEPTH(DEPTH), .N_IRQ(NIRQ)) u0 (
      .clk(clk), .rst_n(rst_n), .step(step), .op_b0(op_b0), .op_b1(op_b1),
      .two_byte(two_byte), .sf(sf), .flags_in(flags_in), .irq_req(irq_req),
      .int_en_set(int_en_set), .int_en_clr(int_en_clr), .sp_wr(sp_wr),
      .sp_wdata(sp_wdata), .pc(pc), .sp(sp), .int_en(int_en), .irq_ack(irq_ack),
      .flags_load(flags_load), .flags_out(flags_out), .stack_ovf(stack_ovf),
      .stack_unf(stack_unf)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int    n_chk = 0, n_fail = 0;
   bit    done = 1'b0;
   string cur_tag = "R1";

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int m_pc, m_sp, m_ie, m_ovf, m_unf, m_fl, m_fout, m_ack;
   int m_spc[DEPTH], m_sfl[DEPTH];

   task automatic m_push(input int p, input int f);
      if (m_sp == DEPTH) m_ovf = 1;
      else begin
         m_spc[m_sp] = p;
         m_sfl[m_sp] = f;
         m_sp++;
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pc = 0; m_sp = 0; m_ie = 0; m_ovf = 0; m_unf = 0;
         m_fl = 0; m_fout = 0; m_ack = 0;
      end else begin
         int b0, b1, nxt1, nxt2;
         bit take;
         b0 = int'(op_b0);
         b1 = int'(op_b1);
         nxt1 = (m_pc + 1) & MASK;
         nxt2 = (m_pc + 2) & MASK;
         m_fl = 0;
         m_ack = 0;
         take = step && (m_ie != 0) && (irq_req != 0);
         if (sp_wr) m_sp = (int'(sp_wdata) > DEPTH) ? DEPTH : int'(sp_wdata);
         if (!step) begin
            if (int_en_set) m_ie = 1;
            else if (int_en_clr) m_ie = 0;
         end else if (take) begin
            int k;
            k = 0;
            while (!irq_req[k]) k++;
            if (!sp_wr) m_push(m_pc, int'(flags_in));
            m_pc = 2 * (k + 1);
            m_ie = 0;
            m_ack = 1 << k;
         end else if ((b0 >> 6) == 0) begin
            m_pc = sf ? ((nxt1 & ~63) | (b0 & 63)) : nxt1;
         end else if ((b0 >> 4) == 'hC) begin
            m_pc = sf ? ((m_pc & ~'hFFF) | ((b0 & 15) << 8) | b1) & MASK : nxt2;
         end else if ((b0 >> 4) == 'hE) begin
            if (!sp_wr) m_push(nxt1, int'(flags_in));
            m_pc = ((b0 & 15) == 0) ? 'h86 : 8 * (b0 & 15) + 6;
         end else if ((b0 >> 3) == 'h08) begin
            if (!sp_wr) m_push(nxt2, int'(flags_in));
            m_pc = ((b0 & 7) << 8) | b1;
         end else if (b0 == 'h4F || b0 == 'h4D) begin
            if (b0 == 'h4D) m_ie = 1;
            if (m_sp == 0) begin
               if (!sp_wr) m_unf = 1;
               m_pc = nxt1;
            end else begin
               if (!sp_wr) m_sp--;
               m_pc = m_spc[m_sp];
               if (b0 == 'h4D) begin
                  m_fl = 1;
                  m_fout = m_sfl[m_sp];
               end
            end
         end else begin
            m_pc = two_byte ? nxt2 : nxt1;
         end
      end
      #(CLK_PERIOD / 4);
      chk(cur_tag, "pc", int'(pc), m_pc);
      chk(cur_tag, "sp", int'(sp), m_sp);
      chk(cur_tag, "int_en", int'(int_en), m_ie);
      chk(cur_tag, "stack_ovf", int'(stack_ovf), m_ovf);
      chk(cur_tag, "stack_unf", int'(stack_unf), m_unf);
      chk(cur_tag, "flags_load", int'(flags_load), m_fl);
      chk(cur_tag, "flags_out", int'(flags_out), m_fout);
      chk(cur_tag, "irq_ack", int'(irq_ack), m_ack);
   end

   task automatic exec(input logic [7:0] b0, input logic [7:0] b1,
                       input bit two, input bit s, input string tag);
      @(negedge clk);
      op_b0 = b0; op_b1 = b1; two_byte = two; sf = s; step = 1'b1; cur_tag = tag;
      @(negedge clk);
      step = 1'b0;
   endtask

   task automatic set_ie(input bit en);
      @(negedge clk);
      int_en_set = en; int_en_clr = !en; cur_tag = "R14";
      @(negedge clk);
      int_en_set = 1'b0; int_en_clr = 1'b0;
   endtask

   task automatic load_sp(input int v);
      @(negedge clk);
      sp_wr = 1'b1; sp_wdata = SPW'(v); cur_tag = "R11";
      @(negedge clk);
      sp_wr = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "pc", int'(pc), 0);
      chk("R1", "sp", int'(sp), 0);
      chk("R1", "int_en", int'(int_en), 0);
      chk("R1", "errors", int'({stack_ovf, stack_unf}), 0);
      rst_n = 1'b1;

      exec(8'hA5, 8'h00, 0, 0, "R2"); chk("R2", "pc", int'(pc), 'h001);
      exec(8'h90, 8'h00, 1, 0, "R2"); chk("R2", "pc", int'(pc), 'h003);
      exec(8'h3C, 8'h00, 0, 1, "R3"); chk("R3", "pc", int'(pc), 'h03C);
      exec(8'h05, 8'h00, 0, 0, "R3"); chk("R3", "pc", int'(pc), 'h03D);
      exec(8'hC7, 8'h89, 1, 1, "R4"); chk("R4", "pc", int'(pc), 'h789);
      exec(8'hC7, 8'h89, 1, 0, "R4"); chk("R4", "pc", int'(pc), 'h78B);
      exec(8'h0A, 8'h00, 0, 1, "R3"); chk("R3", "pc", int'(pc), 'h78A);
      exec(8'hC7, 8'hBF, 1, 1, "R4"); chk("R4", "pc", int'(pc), 'h7BF);
      exec(8'h01, 8'h00, 0, 1, "R3"); chk("R3", "page", int'(pc), 'h7C1);
      exec(8'hCF, 8'hFF, 1, 1, "R4"); chk("R4", "pc", int'(pc), 'hFFF);
      exec(8'h90, 8'h00, 1, 0, "R2"); chk("R2", "pc", int'(pc), 'h1001);
      exec(8'hC2, 8'h34, 1, 1, "R4"); chk("R4", "upper", int'(pc), 'h1234);

      exec(8'hE0, 8'h00, 0, 0, "R5"); chk("R5", "pc", int'(pc), 'h086);
      chk("R5", "sp", int'(sp), 1);
      exec(8'hE3, 8'h00, 0, 0, "R5"); chk("R5", "pc", int'(pc), 'h01E);
      exec(8'h45, 8'h67, 1, 0, "R6"); chk("R6", "pc", int'(pc), 'h567);
      chk("R6", "sp", int'(sp), 3);
      exec(8'h4F, 8'h00, 0, 0, "R7"); chk("R7", "pc", int'(pc), 'h020);
      exec(8'h4F, 8'h00, 0, 0, "R7"); chk("R7", "pc", int'(pc), 'h087);
      exec(8'h4F, 8'h00, 0, 0, "R7"); chk("R7", "pc", int'(pc), 'h1235);
      chk("R7", "sp", int'(sp), 0);

      set_ie(1'b1); chk("R14", "int_en", int'(int_en), 1);
      irq_req = 6'b010100; flags_in = 4'b1010;
      exec(8'hA5, 8'h00, 0, 0, "R10"); chk("R10", "vector", int'(pc), 'h006);
      chk("R9", "irq_ack", int'(irq_ack), 'b000100);
      chk("R9", "int_en", int'(int_en), 0);
      exec(8'hA5, 8'h00, 0, 0, "R9"); chk("R9", "masked", int'(pc), 'h007);
      irq_req = '0; flags_in = 4'b0000;
      exec(8'h4D, 8'h00, 0, 0, "R8"); chk("R8", "pc", int'(pc), 'h1235);
      chk("R8", "flags_load", int'(flags_load), 1);
      chk("R8", "flags_out", int'(flags_out), 'b1010);
      chk("R8", "int_en", int'(int_en), 1);
      irq_req = 6'b100000;
      exec(8'h90, 8'h00, 1, 0, "R10"); chk("R10", "vector", int'(pc), 'h00C);
      irq_req = '0;
      exec(8'h4F, 8'h00, 0, 0, "R7"); chk("R7", "pc", int'(pc), 'h1235);
      chk("R7", "int_en", int'(int_en), 0);
      set_ie(1'b1); set_ie(1'b0); chk("R14", "int_en", int'(int_en), 0);

      load_sp(15); chk("R11", "saturate", int'(sp), DEPTH);
      load_sp(12); chk("R11", "sp", int'(sp), 12);
      exec(8'hE1, 8'h00, 0, 0, "R5"); chk("R5", "pc", int'(pc), 'h00E);
      chk("R11", "sp", int'(sp), 13);
      exec(8'hE2, 8'h00, 0, 0, "R12"); chk("R12", "pc", int'(pc), 'h016);
      chk("R12", "ovf", int'(stack_ovf), 1);
      chk("R12", "sp", int'(sp), 13);
      exec(8'h4F, 8'h00, 0, 0, "R7"); chk("R7", "pc", int'(pc), 'h1236);
      chk("R12", "ovf sticky", int'(stack_ovf), 1);
      load_sp(0);
      exec(8'h4F, 8'h00, 0, 0, "R13"); chk("R13", "pc", int'(pc), 'h1237);
      chk("R13", "unf", int'(stack_unf), 1);
      exec(8'h4D, 8'h00, 0, 0, "R13"); chk("R13", "pc", int'(pc), 'h1238);
      chk("R13", "flags_load", int'(flags_load), 0);
      chk("R13", "int_en", int'(int_en), 1);
      chk("R13", "sp", int'(sp), 0);

      @(negedge clk); rst_n = 1'b0; cur_tag = "R1";
      @(negedge clk);
      chk("R1", "errors", int'({stack_ovf, stack_unf}), 0);
      chk("R1", "pc", int'(pc), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule